// File: doc/BRIEF.md
# Instruction Fetch Accelerator with Prefetch and Trace Buffers

This block sits between a processor's instruction fetch port and a slow flash read port. The flash port needs a fixed number of cycles per line. The block hides that latency in two ways. A one-line prefetch register reads the next sequential line ahead of the processor. A small fully associative trace store keeps recently missed lines, so that short loops can be served again without going to flash.

A fetch that finds its line in the prefetch register completes in the cycle it is issued. A fetch that finds its line in the trace store completes one cycle later. A fetch that misses both costs a full flash access plus one cycle to register the result. The prefetch function is controlled by an accelerator-mode enable, which is set after reset. The trace store has its own enable, which is clear after reset. The trace store works only while the accelerator mode is on. Program or erase activity on the flash discards every buffered line.

The processor keeps `fetch_req` and `fetch_addr` steady until it sees `fetch_rdy`. The transfer takes place at the rising edge where both are high. Addresses are line addresses: the sequential successor of line `a` is `a+1`.

Top module: `ifetch_accel`

## Requirements
- R1: When accelerator mode is on and the prefetch register holds the requested line, `fetch_rdy` is high in the same cycle as the request (zero wait cycles), and the data is the flash content of that line.
- R2: When the prefetch register misses but the enabled trace store holds the line, `fetch_rdy` rises one cycle after the request (one wait cycle).
- R3: A fetch that misses both buffers starts a flash read of its own address on the next edge. That read is held stable for FLASH_LAT cycles, and `fetch_rdy` follows after FLASH_LAT+1 wait cycles.
- R4: In accelerator mode, each completed demand fetch, prefetch hit or trace hit starts a flash read of the next sequential line. A sequential fetch issued after that read has finished is a prefetch hit. A sequential fetch issued while that read is still under way waits for it to finish; immediately after a miss this costs FLASH_LAT-1 wait cycles.
- R5: A non-sequential miss abandons an in-flight prefetch. The flash read address changes to the demand address on the next edge, and the abandoned line never satisfies a later fetch.
- R6: After reset, `fetch_rdy` and `fl_rd` are low and no line is buffered. With the trace enable still clear, revisiting an earlier line that is not the next sequential line is a full miss.
- R7: With accelerator mode off, every fetch is a full miss, no prefetch read is ever started, and the trace store is neither looked up nor filled.
- R8: The trace store holds TB_DEPTH lines and is filled on each demand miss in round-robin order. After TB_DEPTH+1 distinct misses, the oldest line misses again and the others still hit.
- R9: A cycle with the trace enable clear invalidates every trace entry.
- R10: A cycle with `pgm_busy` high invalidates the prefetch register and every trace entry, and abandons an in-flight prefetch.
- R11: `fetch_rdy` is only ever high while `fetch_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pf_en | input | 1 | Accelerator mode: enables prefetch and permits the trace store |
| tb_en | input | 1 | Trace store enable; clear invalidates it |
| pgm_busy | input | 1 | Flash program or erase in progress; invalidates all buffered lines |
| fetch_req | input | 1 | Fetch request, held until `fetch_rdy` |
| fetch_addr | input | AW | Line address of the fetch |
| fetch_rdata | output | DW | Fetched line, valid while `fetch_rdy` is high |
| fetch_rdy | output | 1 | Fetch completes at this edge |
| fl_rd | output | 1 | Flash read in progress |
| fl_addr | output | AW | Flash read line address, stable while a read runs |
| fl_rdata | input | DW | Flash array output for `fl_addr`, sampled after FLASH_LAT cycles |

## Verification
Sequential runs with idle gaps separate a prefetch hit (zero waits) from a miss (FLASH_LAT+1 waits). A back-to-back sequential fetch immediately after a miss shows the wait on an in-flight prefetch. A non-sequential jump straight after a miss shows the prefetch being abandoned, by the flash address it switches to and by the address it never returns. A loop over TB_DEPTH+1 scattered lines separates trace hits from round-robin evictions. Revisits after an enable pulse, a `pgm_busy` pulse, or with accelerator mode off show each kind of invalidation as a return to the full miss latency.

// File: rtl/ifa_pkg.sv
package ifa_pkg;

  // Kind of read that currently owns the flash port
  typedef enum logic {
    OP_DEMAND   = 1'b0,
    OP_PREFETCH = 1'b1
  } fl_op_e;

  // Counter width for a flash access of lat cycles
  function automatic int unsigned lat_bits(input int unsigned lat);
    return (lat > 2) ? $clog2(lat) : 1;
  endfunction

endpackage

// File: rtl/ifa_flash_seq.sv
module ifa_flash_seq
  import ifa_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  fl_op_e        start_op,
  input  logic [AW-1:0] start_addr,
  input  logic          kill_pf,
  output logic          busy,
  output fl_op_e        op,
  output logic [AW-1:0] addr,
  output logic          done
);
  localparam int unsigned CW = lat_bits(LAT);
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      op    <= OP_DEMAND;
      addr  <= '0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      op    <= start_op;
      addr  <= start_addr;
      cnt_q <= LOAD;
    end else if (kill_pf && busy && op == OP_PREFETCH) begin
      busy <= 1'b0;
    end else if (busy) begin
      if (cnt_q == '0) busy <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = busy && (cnt_q == '0);

endmodule

// File: rtl/ifa_trace_buf.sv
module ifa_trace_buf #(
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          lk_en,
  input  logic [AW-1:0] lk_addr,
  output logic          hit,
  output logic [DW-1:0] hit_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0]    tag_q  [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] valid_q;
  logic [DEPTH-1:0] match;
  logic [PW-1:0]    rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (flush) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (wr_en) begin
      valid_q[rr_q] <= 1'b1;
      tag_q[rr_q]   <= wr_addr;
      data_q[rr_q]  <= wr_data;
      rr_q          <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_cmp
    assign match[g] = valid_q[g] && (tag_q[g] == lk_addr);
  end

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < int'(DEPTH); i++)
      if (match[i]) hit_data = hit_data | data_q[i];
  end

  assign hit = lk_en && (|match);

endmodule

// File: rtl/ifetch_accel.sv
module ifetch_accel
  import ifa_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned DW        = 32,
  parameter int unsigned FLASH_LAT = 4,
  parameter int unsigned TB_DEPTH  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_en,
  input  logic          tb_en,
  input  logic          pgm_busy,
  input  logic          fetch_req,
  input  logic [AW-1:0] fetch_addr,
  output logic [DW-1:0] fetch_rdata,
  output logic          fetch_rdy,
  output logic          fl_rd,
  output logic [AW-1:0] fl_addr,
  input  logic [DW-1:0] fl_rdata
);

  function automatic logic [AW-1:0] next_line(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  // flash sequencer view
  logic          fl_busy, fl_done, fl_start;
  fl_op_e        fl_op, fl_start_op;
  logic [AW-1:0] fl_addr_q, fl_start_addr;

  // prefetch register and result register
  logic [AW-1:0] pf_addr_q;
  logic [DW-1:0] pf_data_q, out_q;
  logic          pf_valid_q, out_v_q;

  // trace store view
  logic          tb_on, tb_hit, tb_flush, tb_wr;
  logic [DW-1:0] tb_data;

  // named events
  logic          dem_busy, look, pf_inflight;
  logic          ev_pf_hit, ev_tb_hit, ev_miss, ev_dem_done, ev_pf_done, ev_pf_launch;
  logic [AW-1:0] pf_next;

  assign dem_busy    = fl_busy && (fl_op == OP_DEMAND);
  assign look        = fetch_req && !dem_busy && !out_v_q;
  assign pf_inflight = fl_busy && (fl_op == OP_PREFETCH) && (fl_addr_q == fetch_addr);
  assign tb_on       = pf_en && tb_en;

  assign ev_pf_hit    = look && pf_en && pf_valid_q && (pf_addr_q == fetch_addr);
  assign ev_tb_hit    = look && !ev_pf_hit && !pf_inflight && tb_hit;
  assign ev_miss      = look && !ev_pf_hit && !pf_inflight && !tb_hit;
  assign ev_dem_done  = fl_done && (fl_op == OP_DEMAND);
  assign ev_pf_done   = fl_done && (fl_op == OP_PREFETCH);
  assign ev_pf_launch = pf_en && !pgm_busy && (ev_pf_hit || ev_tb_hit || ev_dem_done);
  assign pf_next      = ev_dem_done ? next_line(fl_addr_q) : next_line(fetch_addr);

  assign fl_start      = ev_miss || ev_pf_launch;
  assign fl_start_op   = ev_miss ? OP_DEMAND : OP_PREFETCH;
  assign fl_start_addr = ev_miss ? fetch_addr : pf_next;

  ifa_flash_seq #(.AW(AW), .LAT(FLASH_LAT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (fl_start),
    .start_op   (fl_start_op),
    .start_addr (fl_start_addr),
    .kill_pf    (pgm_busy),
    .busy       (fl_busy),
    .op         (fl_op),
    .addr       (fl_addr_q),
    .done       (fl_done)
  );

  assign tb_flush = pgm_busy || !tb_on;
  assign tb_wr    = ev_dem_done && tb_on && !pgm_busy;

  ifa_trace_buf #(.AW(AW), .DW(DW), .DEPTH(TB_DEPTH)) u_trace (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (tb_flush),
    .lk_en    (tb_on),
    .lk_addr  (fetch_addr),
    .hit      (tb_hit),
    .hit_data (tb_data),
    .wr_en    (tb_wr),
    .wr_addr  (fl_addr_q),
    .wr_data  (fl_rdata)
  );

  // prefetch register: invalidate > relaunch > fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_valid_q <= 1'b0;
      pf_addr_q  <= '0;
      pf_data_q  <= '0;
    end else if (pgm_busy || !pf_en) begin
      pf_valid_q <= 1'b0;
    end else if (ev_pf_launch) begin
      pf_valid_q <= 1'b0;
      pf_addr_q  <= pf_next;
    end else if (ev_pf_done) begin
      pf_valid_q <= 1'b1;
      pf_data_q  <= fl_rdata;
    end
  end

  // registered result for trace hits and demand reads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      out_v_q <= ev_tb_hit || ev_dem_done;
      if (ev_dem_done)    out_q <= fl_rdata;
      else if (ev_tb_hit) out_q <= tb_data;
    end
  end

  assign fetch_rdy   = out_v_q || ev_pf_hit;
  assign fetch_rdata = out_v_q ? out_q : pf_data_q;
  assign fl_rd       = fl_busy;
  assign fl_addr     = fl_addr_q;

endmodule

// File: rtl/ifetch_accel_chk.sv
module ifetch_accel_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pf_en,
  input logic          tb_en,
  input logic          pgm_busy,
  input logic          fetch_req,
  input logic [AW-1:0] fetch_addr,
  input logic          fetch_rdy,
  input logic          fl_rd,
  input logic [AW-1:0] fl_addr,
  input logic          ev_tb_hit,
  input logic          ev_pf_hit,
  input logic          ev_miss,
  input logic          ev_pf_launch
);

  AST_TB_ONE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tb_hit |=> fetch_rdy); // R2

  AST_MISS_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> (fl_rd && fl_addr == $past(fetch_addr))); // R3

  AST_FL_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_rd && $past(fl_rd) && !$past(ev_miss) && !$past(ev_pf_launch)) |-> $stable(fl_addr)); // R3

  AST_NO_PF_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pf_en && !fetch_req && !fl_rd) |=> !fl_rd); // R7

  AST_TB_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !tb_en |=> !ev_tb_hit); // R9

  AST_PGM_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_busy |=> (!ev_tb_hit && !ev_pf_hit)); // R10

  AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_rdy |-> fetch_req); // R11

endmodule

bind ifetch_accel ifetch_accel_chk #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pf_en        (pf_en),
  .tb_en        (tb_en),
  .pgm_busy     (pgm_busy),
  .fetch_req    (fetch_req),
  .fetch_addr   (fetch_addr),
  .fetch_rdy    (fetch_rdy),
  .fl_rd        (fl_rd),
  .fl_addr      (fl_addr),
  .ev_tb_hit    (ev_tb_hit),
  .ev_pf_hit    (ev_pf_hit),
  .ev_miss      (ev_miss),
  .ev_pf_launch (ev_pf_launch)
);

// File: tb/ifetch_accel_tb_top.sv
`timescale 1ns/1ps
module ifetch_accel_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LAT = 4;
  localparam int DEPTH = 4;
  localparam int GAP = 8;
  localparam int MISS_W = LAT + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_en = 1'b1, tb_en = 1'b0, pgm_busy = 1'b0;
  logic fetch_req = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [DW-1:0] fetch_rdata, fl_rdata;
  logic fetch_rdy, fl_rd;
  logic [AW-1:0] fl_addr;

  int checks = 0;
  int fails = 0;
  int wcnt = 0;

  typedef struct {
    logic [DW-1:0] data;
    int            waits;
    string         tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  // flash array model: content is a fixed function of the line address
  function automatic logic [DW-1:0] flash_word(input logic [AW-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction
  assign fl_rdata = flash_word(fl_addr);

  ifetch_accel #(.AW(AW), .DW(DW), .FLASH_LAT(LAT), .TB_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .pf_en(pf_en), .tb_en(tb_en), .pgm_busy(pgm_busy),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_rdata(fetch_rdata),
    .fetch_rdy(fetch_rdy), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_rdata(fl_rdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: counts wait cycles and compares each completed fetch
  always @(negedge clk) begin
    #2;
    if (rst_n && fetch_req) begin
      if (fetch_rdy) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R11", "unexpected completion", 64'(fetch_addr), 64'(0));
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          checks++;
          if (fetch_rdata !== e.data || wcnt != e.waits) begin
            fails++;
            $display("FAIL %s data/waits: actual %0h/%0d expected %0h/%0d",
                     e.tag, fetch_rdata, wcnt, e.data, e.waits);
          end
        end
        wcnt = 0;
      end else begin
        wcnt++;
      end
    end else if (rst_n && fetch_rdy) begin
      check(1'b0, "R11", "ready without request", 64'(1), 64'(0));
    end
  end

  task automatic issue(input logic [AW-1:0] a, input int waits, input string tag);
    exp_t e;
    e.data = flash_word(a);
    e.waits = waits;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    fetch_req = 1'b1;
    fetch_addr = a;
  endtask

  task automatic finish_fetch();
    while (1) begin
      #1;
      if (fetch_rdy) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    fetch_req = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic fetch(input logic [AW-1:0] a, input int waits, input string tag, input int gap);
    issue(a, waits, tag);
    finish_fetch();
    if (gap > 0) idle(gap);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run hung", 64'(0), 64'(1));
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(fetch_rdy == 1'b0, "R6", "reset rdy", 64'(fetch_rdy), 64'(0));
    check(fl_rd == 1'b0, "R6", "reset fl_rd", 64'(fl_rd), 64'(0));
    rst_n = 1'b1;
    idle(2);

    // sequential run with gaps, trace disabled
    fetch(16'h0100, MISS_W, "R6 first fetch miss R3", GAP);
    fetch(16'h0101, 0, "R1 prefetch hit", GAP);
    fetch(16'h0102, 0, "R4 prefetch hit", GAP);
    fetch(16'h0100, MISS_W, "R6 loop revisit with trace off", GAP);

    // back-to-back sequential: waits on in-flight prefetch
    fetch(16'h0200, MISS_W, "R3 miss", 0);
    fetch(16'h0201, LAT - 1, "R4 in-flight wait", GAP);

    // non-sequential jump abandons the prefetch
    fetch(16'h0310, MISS_W, "R3 miss", 0);
    issue(16'h0400, MISS_W, "R5 jump miss");
    @(negedge clk);
    #1;
    check(fl_rd && fl_addr == 16'h0400, "R5", "flash switched to demand", 64'(fl_addr), 64'(16'h0400));
    finish_fetch();
    idle(GAP);
    fetch(16'h0401, 0, "R5 next after jump", GAP);
    fetch(16'h0311, MISS_W, "R5 abandoned line not kept", GAP);

    // trace store: fill, hit, round-robin eviction
    tb_en = 1'b1;
    fetch(16'h0500, MISS_W, "R8 fill A", GAP);
    fetch(16'h0520, MISS_W, "R8 fill B", GAP);
    fetch(16'h0540, MISS_W, "R8 fill C", GAP);
    fetch(16'h0560, MISS_W, "R8 fill D", GAP);
    fetch(16'h0500, 1, "R2 trace hit A", GAP);
    fetch(16'h0540, 1, "R2 trace hit C", GAP);
    fetch(16'h0580, MISS_W, "R8 fill E evicts A", GAP);
    fetch(16'h0500, MISS_W, "R8 A evicted", GAP);
    fetch(16'h0540, 1, "R8 C kept", GAP);
    fetch(16'h0560, 1, "R8 D kept", GAP);
    fetch(16'h0580, 1, "R8 E kept", GAP);
    fetch(16'h0520, MISS_W, "R8 B evicted by A", GAP);

    // enable pulse invalidates the trace store
    @(negedge clk) tb_en = 1'b0;
    @(negedge clk) tb_en = 1'b1;
    fetch(16'h0580, MISS_W, "R9 E invalid after clear", GAP);
    fetch(16'h0560, MISS_W, "R9 D invalid after clear", GAP);

    // program/erase activity invalidates everything
    fetch(16'h0600, MISS_W, "R10 fill F", GAP);
    fetch(16'h0620, MISS_W, "R10 fill G", GAP);
    @(negedge clk) pgm_busy = 1'b1;
    @(negedge clk) pgm_busy = 1'b0;
    fetch(16'h0621, MISS_W, "R10 prefetch line dropped", GAP);
    fetch(16'h0600, MISS_W, "R10 trace line dropped", GAP);

    // accelerator mode off
    @(negedge clk) pf_en = 1'b0;
    fetch(16'h0700, MISS_W, "R7 miss with mode off", 0);
    @(negedge clk);
    fetch_req = 1'b0;
    #1;
    check(fl_rd == 1'b0, "R7", "no prefetch started", 64'(fl_rd), 64'(0));
    idle(GAP);
    fetch(16'h0701, MISS_W, "R7 sequential still misses", GAP);
    fetch(16'h0700, MISS_W, "R7 no trace with mode off", GAP);

    idle(4);
    check(sb_q.size() == 0, "R11", "all fetches completed", 64'(sb_q.size()), 64'(0));
    summary();
    $finish;
  end

endmodule